// File: doc/BRIEF.md
# Chip-Enable Toggle Watchdog and Power-Fail Reset Supervisor

This block watches a host processor through the chip-enable line of a serial peripheral port. The host shows that it is alive by raising and then dropping chip-enable without running any serial transfer during that window. Each such bare toggle restarts a timeout counter that advances on a slow timebase tick. If no valid toggle arrives before the programmed number of ticks has passed, the block drives an active-low CPU reset for a fixed number of ticks. It then releases the reset and starts timing again.

The same reset output also serves power-fail supervision. While the power-down sense input is active, the reset is held low and the power-switch enable output is dropped. When power returns, the reset stays low for a short number of further ticks. A software-owned enable bit gates the reset output as a whole. The power-switch enable does not depend on that bit.

Top module: `cewd_supervisor`

## Requirements
- R1: While `wd_en_i` is low, `cpu_rst_n_o` stays high, whatever the other inputs do. The timeout counter is held at zero, so after re-enabling, a full timeout of ticks is needed again.
- R2: With the enable high and no valid service, `cpu_rst_n_o` goes low in the clock after the tick that completes `timeout_i` ticks since the last restart. A `timeout_i` of 0 behaves as 1. Clock cycles without `tick_i` high do not advance the count.
- R3: A valid service is a period in which chip-enable is sampled active, followed by a clock in which it is sampled inactive. With the default `CE_ACTIVE_HIGH=1`, active means `ce_i` is high. On that clock the timeout counter restarts from zero, and a tick in the same clock is not counted.
- R4: If `xfer_i` is sampled high in any clock in which chip-enable was active, the toggle that ends that active period is not a service. The counter keeps its count.
- R5: A timeout reset lasts exactly `PULSE_TICKS` ticks (8 by default). Services during it are ignored. After release, the counter restarts from zero.
- R6: When `pwr_down_i` is high and the enable is high, `cpu_rst_n_o` is low from the next clock for as long as the input stays high. The timeout counter is held at zero during this time and during its release delay.
- R7: `pwr_sw_en_o` goes low one clock after `pwr_down_i` rises and high one clock after it falls. The enable bit does not affect it.
- R8: After `pwr_down_i` falls, `cpu_rst_n_o` is released on the `PD_HOLD_TICKS`-th tick (2 by default). Before that tick it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip-enable line, already synchronous to clk |
| xfer_i | input | 1 | High in clocks where serial transfer activity is seen |
| tick_i | input | 1 | One-clock timebase tick |
| pwr_down_i | input | 1 | Power-down sense, synchronous |
| wd_en_i | input | 1 | Software enable of the CPU reset function |
| timeout_i | input | TO_W | Timeout in ticks (0 treated as 1) |
| cpu_rst_n_o | output | 1 | Active-low CPU reset |
| pwr_sw_en_o | output | 1 | Power-switch enable, low during power-down |

## Verification
Faults in this block show up on `cpu_rst_n_o`, and they show up within a tick or two of the point where they go wrong. If the count is off by one, the reset falls one tick early or late relative to `timeout_i`. If the service detector is wrong, a clean toggle fails to postpone the reset, or a toggle that carried a transfer wrongly postpones it. If the pulse or hold counters are wrong, the release edge moves away from the 8th tick or the 2nd tick. If the counter fails to clear after a pulse, the next reset comes early. The power-switch output shows a wrong power-down latch in the very next clock.

// File: rtl/cewd_pkg.sv
package cewd_pkg;

   localparam int unsigned DEF_TO_W          = 16;
   localparam int unsigned DEF_PULSE_TICKS   = 8;
   localparam int unsigned DEF_PD_HOLD_TICKS = 2;

   // source currently holding the CPU in reset
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_WDOG = 2'd1,
      CAUSE_PWR  = 2'd2
   } rst_cause_e;

endpackage

// File: rtl/cewd_kick_detect.sv
module cewd_kick_detect #(
   parameter bit CE_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   input  logic xfer_i,
   output logic kick_o
);

   logic sel_act;
   logic act_q;
   logic dirty_q;

   generate
      if (CE_ACTIVE_HIGH) begin : g_pol_high
         assign sel_act = ce_i;
      end else begin : g_pol_low
         assign sel_act = ~ce_i;
      end
   endgenerate

   // dirty_q remembers any transfer activity seen during the active window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         act_q <= sel_act;
         if (sel_act && !act_q)
            dirty_q <= xfer_i;
         else if (sel_act && xfer_i)
            dirty_q <= 1'b1;
      end
   end

   assign kick_o = act_q && !sel_act && !dirty_q;

   // R4: a transfer seen while active blocks the kick at the closing edge
   p_dirty_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act && xfer_i) |=> !kick_o);

endmodule

// File: rtl/cewd_timeout_ctr.sv
module cewd_timeout_ctr #(
   parameter int unsigned TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic            tick_i,
   input  logic            kick_i,
   input  logic [TO_W-1:0] limit_i,
   output logic [TO_W-1:0] cnt_o,
   output logic            expire_o
);

   localparam int unsigned CW = TO_W + 1;

   logic [TO_W-1:0] cnt_q;
   logic [CW-1:0]   eff_lim;
   logic [CW-1:0]   next_cnt;

   assign eff_lim  = (limit_i == '0) ? CW'(1) : {1'b0, limit_i};
   assign next_cnt = {1'b0, cnt_q} + CW'(1);
   assign expire_o = run_i && !kick_i && tick_i && (next_cnt >= eff_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || kick_i || expire_o)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= next_cnt[TO_W-1:0];
   end

   assign cnt_o = cnt_q;

   // R2: the counter only moves on a tick
   p_no_tick_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && run_i && !kick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cewd_rst_shaper.sv
module cewd_rst_shaper
   import cewd_pkg::*;
#(
   parameter int unsigned PULSE_TICKS   = DEF_PULSE_TICKS,
   parameter int unsigned PD_HOLD_TICKS = DEF_PD_HOLD_TICKS
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       expire_i,
   input  logic       pwr_down_i,
   output logic       wdog_busy_o,
   output logic       pwr_busy_o,
   output logic       pd_seen_o,
   output rst_cause_e cause_o
);

   localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
   localparam int unsigned HW = $clog2(PD_HOLD_TICKS + 1);

   logic [PW-1:0] pulse_q;
   logic [HW-1:0] hold_q;
   logic          pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= '0;
      end else if (expire_i) begin
         pulse_q <= PW'(PULSE_TICKS);
      end else if (tick_i && pulse_q != '0) begin
         pulse_q <= pulse_q - PW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q   <= 1'b0;
         hold_q <= '0;
      end else begin
         pd_q <= pwr_down_i;
         if (pd_q)
            hold_q <= HW'(PD_HOLD_TICKS);
         else if (tick_i && hold_q != '0)
            hold_q <= hold_q - HW'(1);
      end
   end

   assign wdog_busy_o = (pulse_q != '0);
   assign pwr_busy_o  = pd_q || (hold_q != '0);
   assign pd_seen_o   = pd_q;

   always_comb begin
      if (pwr_busy_o)
         cause_o = CAUSE_PWR;
      else if (wdog_busy_o)
         cause_o = CAUSE_WDOG;
      else
         cause_o = CAUSE_NONE;
   end

   // R5: an expiry always starts a pulse
   p_expire_starts_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i |=> wdog_busy_o);

   // R8: the release delay starts as soon as power-down clears
   p_hold_after_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_q) |-> pwr_busy_o);

endmodule

// File: rtl/cewd_supervisor.sv
module cewd_supervisor
   import cewd_pkg::*;
#(
   parameter int unsigned TO_W           = DEF_TO_W,
   parameter int unsigned PULSE_TICKS    = DEF_PULSE_TICKS,
   parameter int unsigned PD_HOLD_TICKS  = DEF_PD_HOLD_TICKS,
   parameter bit          CE_ACTIVE_HIGH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_i,
   input  logic            xfer_i,
   input  logic            tick_i,
   input  logic            pwr_down_i,
   input  logic            wd_en_i,
   input  logic [TO_W-1:0] timeout_i,
   output logic            cpu_rst_n_o,
   output logic            pwr_sw_en_o
);

   initial begin
      a_to_w: assert (TO_W >= 1 && TO_W <= 32)
         else $error("TO_W out of range");
      a_pulse: assert (PULSE_TICKS >= 1)
         else $error("PULSE_TICKS must be at least 1");
      a_hold: assert (PD_HOLD_TICKS >= 1)
         else $error("PD_HOLD_TICKS must be at least 1");
   end

   logic            kick;
   logic            expire;
   logic            run;
   logic            wdog_busy;
   logic            pwr_busy;
   logic            pd_seen;
   logic [TO_W-1:0] cnt;
   rst_cause_e      cause;

   cewd_kick_detect #(
      .CE_ACTIVE_HIGH (CE_ACTIVE_HIGH)
   ) u_kick (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_i   (ce_i),
      .xfer_i (xfer_i),
      .kick_o (kick)
   );

   assign run = wd_en_i && !wdog_busy && !pwr_busy;

   cewd_timeout_ctr #(
      .TO_W (TO_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .tick_i   (tick_i),
      .kick_i   (kick),
      .limit_i  (timeout_i),
      .cnt_o    (cnt),
      .expire_o (expire)
   );

   cewd_rst_shaper #(
      .PULSE_TICKS   (PULSE_TICKS),
      .PD_HOLD_TICKS (PD_HOLD_TICKS)
   ) u_shape (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .expire_i    (expire),
      .pwr_down_i  (pwr_down_i),
      .wdog_busy_o (wdog_busy),
      .pwr_busy_o  (pwr_busy),
      .pd_seen_o   (pd_seen),
      .cause_o     (cause)
   );

   assign cpu_rst_n_o = !(wd_en_i && (cause != CAUSE_NONE));
   assign pwr_sw_en_o = !pd_seen;

   // R1: disabled means no reset and a cleared counter
   p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en_i |-> cpu_rst_n_o);
   p_disabled_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en_i |=> cnt == '0);

   // R3: a kick while running restarts the counter
   p_kick_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (kick && run) |=> cnt == '0);

   // R6: power-down with enable holds the reset low
   p_pd_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_seen && wd_en_i) |-> !cpu_rst_n_o);

   // R7: switch enable follows the sensed power state one clock later
   p_sw_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down_i |=> !pwr_sw_en_o);

endmodule

// File: tb/cewd_supervisor_tb.sv
module cewd_supervisor_tb;

   localparam int TO_W = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            ce_i, xfer_i, tick_i, pwr_down_i, wd_en_i;
   logic [TO_W-1:0] timeout_i;
   logic            cpu_rst_n_o, pwr_sw_en_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cewd_supervisor #(.TO_W(TO_W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ce_i        (ce_i),
      .xfer_i      (xfer_i),
      .tick_i      (tick_i),
      .pwr_down_i  (pwr_down_i),
      .wd_en_i     (wd_en_i),
      .timeout_i   (timeout_i),
      .cpu_rst_n_o (cpu_rst_n_o),
      .pwr_sw_en_o (pwr_sw_en_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ce_i = 1'b0; xfer_i = 1'b0; tick_i = 1'b0;
      pwr_down_i = 1'b0; wd_en_i = 1'b0; timeout_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic toggle_ce(input bit with_xfer);
      ce_i = 1'b1;
      @(negedge clk);
      if (with_xfer) xfer_i = 1'b1;
      @(negedge clk);
      xfer_i = 1'b0;
      @(negedge clk);
      ce_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 reset cpu_rst_n", cpu_rst_n_o, 1'b1);
      chk("R7 reset pwr_sw_en", pwr_sw_en_o, 1'b1);
   endtask

   task automatic t_timeout_and_pulse();
      do_reset();
      wd_en_i = 1'b1; timeout_i = 16'd5;
      @(negedge clk);
      ticks(4);
      repeat (10) @(negedge clk);
      chk("R2 before limit", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R2 at limit", cpu_rst_n_o, 1'b0);
      ticks(7);
      chk("R5 pulse 7 ticks", cpu_rst_n_o, 1'b0);
      ticks(1);
      chk("R5 pulse released", cpu_rst_n_o, 1'b1);
      ticks(4);
      chk("R5 restart from zero", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R5 second timeout", cpu_rst_n_o, 1'b0);
      toggle_ce(1'b0);
      ticks(7);
      chk("R5 kick ignored in pulse", cpu_rst_n_o, 1'b0);
      ticks(1);
      chk("R5 released after kick", cpu_rst_n_o, 1'b1);
   endtask

   task automatic t_service();
      do_reset();
      wd_en_i = 1'b1; timeout_i = 16'd5;
      @(negedge clk);
      ticks(4);
      toggle_ce(1'b0);
      ticks(4);
      chk("R3 clean toggle restarts", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R3 timeout after restart", cpu_rst_n_o, 1'b0);
   endtask

   task automatic t_dirty_toggle();
      do_reset();
      wd_en_i = 1'b1; timeout_i = 16'd5;
      @(negedge clk);
      ticks(4);
      toggle_ce(1'b1);
      chk("R4 before tick", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R4 transfer voids service", cpu_rst_n_o, 1'b0);
   endtask

   task automatic t_disable();
      do_reset();
      timeout_i = 16'd3;
      ticks(10);
      chk("R1 disabled no reset", cpu_rst_n_o, 1'b1);
      wd_en_i = 1'b1;
      @(negedge clk);
      ticks(2);
      chk("R1 counter was cleared", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R1 counts after enable", cpu_rst_n_o, 1'b0);
      wd_en_i = 1'b0;
      @(negedge clk);
      chk("R1 disable masks pulse", cpu_rst_n_o, 1'b1);
   endtask

   task automatic t_zero_timeout();
      do_reset();
      wd_en_i = 1'b1; timeout_i = 16'd0;
      @(negedge clk);
      chk("R2 zero before tick", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R2 zero acts as one", cpu_rst_n_o, 1'b0);
   endtask

   task automatic t_power_down();
      do_reset();
      wd_en_i = 1'b1; timeout_i = 16'd3;
      @(negedge clk);
      pwr_down_i = 1'b1;
      @(negedge clk);
      chk("R6 reset on power-down", cpu_rst_n_o, 1'b0);
      chk("R7 switch off", pwr_sw_en_o, 1'b0);
      ticks(6);
      chk("R6 held while down", cpu_rst_n_o, 1'b0);
      pwr_down_i = 1'b0;
      @(negedge clk);
      chk("R7 switch back on", pwr_sw_en_o, 1'b1);
      chk("R8 still low at return", cpu_rst_n_o, 1'b0);
      ticks(1);
      chk("R8 low after 1 tick", cpu_rst_n_o, 1'b0);
      ticks(1);
      chk("R8 released after 2 ticks", cpu_rst_n_o, 1'b1);
      ticks(2);
      chk("R6 counter held at zero", cpu_rst_n_o, 1'b1);
      ticks(1);
      chk("R6 counts after release", cpu_rst_n_o, 1'b0);
   endtask

   task automatic t_power_down_disabled();
      do_reset();
      pwr_down_i = 1'b1;
      @(negedge clk);
      chk("R7 switch off when disabled", pwr_sw_en_o, 1'b0);
      chk("R1 no reset when disabled", cpu_rst_n_o, 1'b1);
      pwr_down_i = 1'b0;
      @(negedge clk);
      chk("R7 switch on when disabled", pwr_sw_en_o, 1'b1);
   endtask

   initial begin
      #600000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_timeout_and_pulse();
      t_service();
      t_dirty_toggle();
      t_disable();
      t_zero_timeout();
      t_power_down();
      t_power_down_disabled();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule